// File: doc/BRIEF.md
# Offset Min-Sum Check Node Unit

This block is the arithmetic element for one check node of a layered, row-serial LDPC decoder. It takes the variable-to-check messages of every edge that one base-matrix row connects to that node, up to `EDGES` of them. For each edge it returns the extrinsic check-to-variable message, which depends only on the other connected edges. A decoder lifted by a factor Z places Z copies side by side and feeds them one base row at a time. Message storage, cyclic shifting and the posterior update sit outside this block.

Messages are `W`-bit two's-complement LLRs with one fractional bit, so one LSB is 0.5. Each outgoing magnitude is the smallest magnitude among the other connected edges, less one LSB as the offset and floored at zero. Each outgoing sign is the product of the other connected edges' signs. The block finds these values by tracking the smallest and second-smallest magnitudes, the position of the smallest, and the parity of all signs. It uses only adders, comparators and selects.

Both sides are valid/ready streams. A row is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its results are registered and appear on `out_msgs` with `out_valid` one cycle later. `in_ready` is high when the output register is empty or when the consumer takes its contents in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its value and no new row is accepted. A new row can be accepted on every cycle that the consumer keeps `out_ready` high.

Top module: `cnu_offset_minsum`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_msgs` does not change. When the output is taken and no row is offered, `out_valid` falls on the next edge.
- R3: For a connected edge, the output magnitude is max(m − 1, 0). Here m is the smallest clamped magnitude among the other connected edges. Equivalently, the edge that holds the overall minimum receives the second minimum, and every other edge receives the minimum.
- R4: When several edges tie for the smallest magnitude, the lowest-indexed of them owns the minimum. Every edge, including the owner, then receives the tied value less one LSB.
- R5: For a connected edge, the output is negative exactly when an odd number of the other connected edges carry a negative input. A zero input counts as positive.
- R6: An input of −2^(W−1) (−32 for W=6) is treated as magnitude 2^(W−1)−1. Every output lies within ±(2^(W−1)−1), and −2^(W−1) never appears.
- R7: An edge whose bit in `in_mask` is 0 gets an output of 0. Its input affects neither the magnitude nor the sign of any other edge.
- R8: If a connected edge has no other connected edge, its minimum is taken as 2^(W−1)−1, so its output magnitude is 2^(W−1)−2 (30 for W=6). If no edge is connected, all outputs are 0.
- R9: A row accepted on one clock edge is on `out_msgs` with `out_valid` high after that edge. Edge e occupies bits [e·W +: W] of both `in_msgs` and `out_msgs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A row of messages is offered |
| in_ready | output | 1 | The unit accepts the offered row |
| in_msgs | input | EDGES·W | Variable-to-check messages, edge e at [e·W +: W] |
| in_mask | input | EDGES | Bit e is 1 when edge e is connected |
| out_valid | output | 1 | Output row holds a result |
| out_ready | input | 1 | Consumer takes the output row |
| out_msgs | output | EDGES·W | Check-to-variable messages, edge e at [e·W +: W] |

## Verification
The assertions take for granted that `in_msgs`, `in_mask` and the two handshake inputs carry known values on every clock edge after reset, and that the consumer may drop `out_ready` at any time. The stimulus changes every input only on the falling clock edge and keeps every input defined throughout. It sweeps all connection masks of a four-edge unit against a value set that includes −32, +31, zero and repeated values, so saturation, ties and single-edge rows all occur. A separate back-pressure sequence stalls the consumer while a second row waits, which exercises the hold and pass-through rules.

// File: rtl/cnu_pkg.sv
package cnu_pkg;
  // Default geometry: one row of an 8-column base matrix, 6-bit LLRs.
  localparam int unsigned CNU_DEF_EDGES = 8;
  localparam int unsigned CNU_DEF_WIDTH = 6;
  // Offset in LSBs (0.5 with one fractional bit).
  localparam int unsigned CNU_OFFSET_LSB = 1;
endpackage

// File: rtl/cnu_edge_prep.sv
// Splits one incoming message into a clamped magnitude and a masked sign.
module cnu_edge_prep #(
  parameter int unsigned W = cnu_pkg::CNU_DEF_WIDTH
) (
  input  logic [W-1:0] msg,
  input  logic         en,
  output logic [W-2:0] mag,
  output logic         sgn
);
  logic [W-1:0] negated;
  logic         is_most_neg;

  always_comb begin
    negated     = -msg;
    is_most_neg = (msg == {1'b1, {(W-1){1'b0}}});
    if (is_most_neg)      mag = {(W-1){1'b1}};   // R6 clamp
    else if (msg[W-1])    mag = negated[W-2:0];
    else                  mag = msg[W-2:0];
    sgn = en & msg[W-1];
  end
endmodule

// File: rtl/cnu_min_track.sv
// Finds the two smallest magnitudes among connected edges and the owner of
// the smallest one; strict comparison gives ties to the lowest index (R4).
module cnu_min_track #(
  parameter int unsigned EDGES = cnu_pkg::CNU_DEF_EDGES,
  parameter int unsigned MW    = cnu_pkg::CNU_DEF_WIDTH - 1,
  localparam int unsigned IDXW = (EDGES > 1) ? $clog2(EDGES) : 1
) (
  input  logic [EDGES*MW-1:0] mags,
  input  logic [EDGES-1:0]    en,
  output logic [MW-1:0]       min1,
  output logic [MW-1:0]       min2,
  output logic [IDXW-1:0]     owner
);
  always_comb begin
    min1  = {MW{1'b1}};
    min2  = {MW{1'b1}};
    owner = '0;
    for (int i = 0; i < EDGES; i++) begin
      if (en[i]) begin
        if (mags[i*MW +: MW] < min1) begin
          min2  = min1;
          min1  = mags[i*MW +: MW];
          owner = IDXW'(i);
        end else if (mags[i*MW +: MW] < min2) begin
          min2 = mags[i*MW +: MW];
        end
      end
    end
  end

  // The second minimum can never undercut the first.
  always_comb begin
    p_order_r3: assert (min1 <= min2)
      else $error("min tracker order broken");
  end
endmodule

// File: rtl/cnu_edge_out.sv
// Applies the offset, sign and saturation for one outgoing edge.
module cnu_edge_out #(
  parameter int unsigned W = cnu_pkg::CNU_DEF_WIDTH
) (
  input  logic [W-2:0] mag,
  input  logic         neg,
  input  logic         en,
  output logic [W-1:0] msg
);
  localparam int unsigned MW = W - 1;
  localparam logic [MW-1:0] OFS = MW'(cnu_pkg::CNU_OFFSET_LSB);
  localparam logic signed [W:0] SAT_HI = (W+1)'((1 << (W-1)) - 1);
  localparam logic signed [W:0] SAT_LO = -SAT_HI;

  logic [MW-1:0]       reduced;
  logic signed [W:0]   wide;

  always_comb begin
    reduced = (mag > OFS) ? (mag - OFS) : '0;
    wide    = neg ? -$signed({2'b00, reduced}) : $signed({2'b00, reduced});
    if (wide > SAT_HI)      wide = SAT_HI;
    else if (wide < SAT_LO) wide = SAT_LO;
    msg = en ? wide[W-1:0] : '0;
  end
endmodule

// File: rtl/cnu_offset_minsum.sv
module cnu_offset_minsum #(
  parameter int unsigned EDGES = cnu_pkg::CNU_DEF_EDGES,
  parameter int unsigned W     = cnu_pkg::CNU_DEF_WIDTH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [EDGES*W-1:0]   in_msgs,
  input  logic [EDGES-1:0]     in_mask,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [EDGES*W-1:0]   out_msgs
);
  localparam int unsigned MW   = W - 1;
  localparam int unsigned IDXW = (EDGES > 1) ? $clog2(EDGES) : 1;

  logic [EDGES*MW-1:0] mags;
  logic [EDGES-1:0]    sgns;
  logic [MW-1:0]       min1, min2;
  logic [IDXW-1:0]     owner;
  logic                parity;
  logic [EDGES*W-1:0]  next_msgs;
  logic                take;

  genvar e;
  generate
    for (e = 0; e < EDGES; e++) begin : g_prep
      cnu_edge_prep #(.W(W)) u_prep (
        .msg (in_msgs[e*W +: W]),
        .en  (in_mask[e]),
        .mag (mags[e*MW +: MW]),
        .sgn (sgns[e])
      );
    end
  endgenerate

  cnu_min_track #(.EDGES(EDGES), .MW(MW)) u_track (
    .mags  (mags),
    .en    (in_mask),
    .min1  (min1),
    .min2  (min2),
    .owner (owner)
  );

  assign parity = ^sgns;

  generate
    for (e = 0; e < EDGES; e++) begin : g_out
      logic [MW-1:0] pick;
      assign pick = (owner == IDXW'(e)) ? min2 : min1;
      cnu_edge_out #(.W(W)) u_out (
        .mag (pick),
        .neg (parity ^ sgns[e]),
        .en  (in_mask[e]),
        .msg (next_msgs[e*W +: W])
      );
    end
  endgenerate

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_msgs  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_msgs  <= next_msgs;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // Stalled output keeps its row.
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_msgs));

  // Drained output with nothing offered goes empty.
  p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  // An accepted row is presented on the next cycle.
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  generate
    for (e = 0; e < EDGES; e++) begin : g_chk
      p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_msgs[e*W +: W] != {1'b1, {(W-1){1'b0}}});
      p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_mask[e] |=> out_msgs[e*W +: W] == '0);
    end
  endgenerate
endmodule

// File: tb/cnu_offset_minsum_test.sv
module cnu_offset_minsum_test;
  localparam int CLK_PERIOD = 10;
  localparam int E = 4;
  localparam int W = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [E*W-1:0] in_msgs = '0;
  logic [E-1:0]   in_mask = '0;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [E*W-1:0] out_msgs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnu_offset_minsum #(.EDGES(E), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_msgs(in_msgs), .in_mask(in_mask), .out_valid(out_valid),
    .out_ready(out_ready), .out_msgs(out_msgs)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Extrinsic min over the other connected edges, then offset and sign.
  function automatic int expect_edge(int v[E], bit [E-1:0] m, int e);
    int mn = 31;
    int s = 0;
    int a;
    if (!m[e]) return 0;
    for (int j = 0; j < E; j++) begin
      if (j != e && m[j]) begin
        a = (v[j] < 0) ? -v[j] : v[j];
        if (a > 31) a = 31;
        if (a < mn) mn = a;
        if (v[j] < 0) s ^= 1;
      end
    end
    mn = (mn > 0) ? mn - 1 : 0;
    return s ? -mn : mn;
  endfunction

  function automatic string tag_for(int v[E], bit [E-1:0] m, int e);
    int cnt = 0;
    bit tie = 1'b0;
    for (int j = 0; j < E; j++) if (m[j]) cnt++;
    for (int j = 0; j < E; j++)
      for (int k = j + 1; k < E; k++)
        if (m[j] && m[k] && j != e && k != e && v[j] == v[k]) tie = 1'b1;
    if (!m[e]) return "R7";
    if (cnt == 1) return "R8";
    if (v[e] == -32) return "R6";
    if (tie) return "R4";
    return "R3/R5";
  endfunction

  task automatic drive(int v[E], bit [E-1:0] m);
    for (int e = 0; e < E; e++) in_msgs[e*W +: W] = W'(v[e]);
    in_mask = m;
  endtask

  task automatic check_row(int v[E], bit [E-1:0] m);
    check("R9 out_valid", int'(out_valid), 1);
    for (int e = 0; e < E; e++)
      check(tag_for(v, m, e), int'($signed(out_msgs[e*W +: W])),
            expect_edge(v, m, e));
  endtask

  initial begin
    int vals[6] = '{-32, -5, -1, 0, 1, 31};
    int cur[E];
    int prev[E];
    bit [E-1:0] prev_m;
    bit have_prev = 1'b0;
    int ra[E] = '{3, -7, 0, 12};
    int rb[E] = '{-2, -2, 9, -32};

    repeat (3) @(negedge clk);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", int'(out_valid), 0);

    // Sweep: every mask against every 4-tuple of the value set.
    in_valid = 1'b1;
    for (int m = 0; m < 16; m++)
      for (int a = 0; a < 6; a++)
        for (int b = 0; b < 6; b++)
          for (int c = 0; c < 6; c++)
            for (int d = 0; d < 6; d++) begin
              cur = '{vals[a], vals[b], vals[c], vals[d]};
              if (have_prev) check_row(prev, prev_m);
              drive(cur, 4'(m));
              prev = cur;
              prev_m = 4'(m);
              have_prev = 1'b1;
              @(negedge clk);
            end
    check_row(prev, prev_m);

    // Drain: nothing offered, consumer ready.
    in_valid = 1'b0;
    @(negedge clk);
    check("R2 drain", int'(out_valid), 0);

    // Back-pressure: row A stalls while row B waits.
    out_ready = 1'b0;
    drive(ra, 4'hF);
    in_valid = 1'b1;
    @(negedge clk);
    check_row(ra, 4'hF);
    drive(rb, 4'b1011);
    check("R2 ready low", int'(in_ready), 0);
    repeat (2) @(negedge clk);
    check_row(ra, 4'hF);
    check("R2 still stalled", int'(in_ready), 0);
    out_ready = 1'b1;
    #1;
    check("R2 ready passthrough", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    check_row(rb, 4'b1011);
    @(negedge clk);
    check("R2 empty", int'(out_valid), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule